// File: doc/BRIEF.md
# DRAM Manual Command Sequencer

This block issues single DRAM commands on software request. Software writes one 32-bit word that holds an opcode, a rank mask, a 16-bit argument and a start bit. When that word is accepted, the block drives a one-cycle command strobe with the opcode, rank selects and argument. It then holds the start bit high for a fixed number of cycles set per opcode, and clears the start bit to mark completion. The read-back word therefore works as the busy flag that firmware polls.

A mode-register read is different. After its strobe the block waits for a read-valid handshake from the physical layer. It latches the returned byte into a separate status output and completes on that same edge. A refresh aimed at both ranks is split into two strobes, rank 0 first and then rank 1, each followed by the refresh delay. Opcodes outside the defined set, and an empty rank mask, record their fields but launch nothing.

Top module: `dram_mcmd_top`

## Requirements
- R1: While reset is held and just after it, the read-back word and the status byte are zero and no strobe is driven.
- R2: Word layout: bit 31 is start, bits [21:20] are the rank mask (1 = rank 0, 2 = rank 1, 3 = both), bits [19:4] are the argument (the mode-register address is argument bits [7:0], i.e. word bits [11:4]), and bits [3:0] are the opcode. A write with bit 31 clear updates the fields without launching. The read-back word returns the recorded fields in the same positions, with all other bits zero.
- R3: Opcode encodings are: 0 deselect, 1 precharge-all, 2 refresh, 3 mode-register set, 4 short ZQ, 5 long ZQ, 6 reset-low, 8 mode-register read, 9 deep-power-down entry. Each launched command drives the strobe with its opcode, rank mask and argument.
- R4: For every opcode other than mode-register read and the two-rank refresh, the start bit reads 1 for exactly D+1 cycles after the accepting edge, where D is that opcode's delay parameter, and exactly one strobe is issued.
- R5: A refresh with mask 3 strobes rank 0 (select 01), then rank 1 (select 10). The start bit stays set for 2*(D+1) cycles.
- R6: A mode-register read keeps start set until read-valid arrives. On that edge it latches the read data into the status byte and clears start.
- R7: A write that arrives while start reads 1 is ignored: the fields and the command in progress do not change, and no extra strobe follows.
- R8: A write with start set but an undefined opcode or a zero rank mask records its fields, leaves start at 0 and issues no strobe.
- R9: Read-valid outside a pending mode-register read leaves the status byte unchanged.
- R10: The strobe never lasts more than one cycle in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe for the command word |
| wr_data | input | 32 | Command word written by software |
| cmd_rdata | output | 32 | Read-back of the command word, with start as the busy flag |
| mrr_stat | output | 8 | Latched mode-register read data |
| cmd_stb | output | 1 | One-cycle command strobe toward the physical layer |
| cmd_op | output | 4 | Opcode of the strobed command |
| cmd_rank | output | 2 | Rank selects of the strobed command |
| cmd_arg | output | 16 | Argument of the strobed command |
| rd_valid | input | 1 | Mode-register read data valid from the physical layer |
| rd_data | input | 8 | Mode-register read data |

## Verification
The bench measures how long the busy flag stays set, to the exact cycle, for each opcode. An off-by-one in the delay counter would show up as a count one too long or one too short. For the two-rank refresh it checks both the order and the number of strobes. A design that broadcast both ranks at once, or completed after the first rank, would give a single strobe or half the busy time. It also writes a new command in the middle of a long calibration, which exposes a design that overwrites the fields in flight or strobes twice. Finally, it pulses read-valid while no read is pending, which exposes a status register that latches without a pending read. Undefined opcodes and an empty rank mask must finish without any strobe and without setting start.

// File: rtl/mcmd_pkg.sv
package mcmd_pkg;

    localparam int WORD_W    = 32;
    localparam int START_BIT = 31;
    localparam int RANK_LSB  = 20;
    localparam int RANK_W    = 2;
    localparam int ARG_LSB   = 4;
    localparam int ARG_W     = 16;
    localparam int OP_W      = 4;

    typedef enum logic [OP_W-1:0] {
        OP_DESEL = 4'd0,
        OP_PREA  = 4'd1,
        OP_REF   = 4'd2,
        OP_MRS   = 4'd3,
        OP_ZQS   = 4'd4,
        OP_ZQL   = 4'd5,
        OP_RSTL  = 4'd6,
        OP_MRR   = 4'd8,
        OP_DPDE  = 4'd9
    } op_e;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [RANK_W-1:0] rank;
        logic [ARG_W-1:0]  arg;
    } cmd_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_WAIT_RD
    } seq_e;

    function automatic logic op_known(input logic [OP_W-1:0] op);
        logic k;
        case (op)
            OP_DESEL, OP_PREA, OP_REF, OP_MRS, OP_ZQS,
            OP_ZQL, OP_RSTL, OP_MRR, OP_DPDE: k = 1'b1;
            default:                          k = 1'b0;
        endcase
        return k;
    endfunction

    function automatic cmd_t word_to_cmd(input logic [WORD_W-1:0] w);
        cmd_t c;
        c.op   = w[OP_W-1:0];
        c.rank = w[RANK_LSB +: RANK_W];
        c.arg  = w[ARG_LSB +: ARG_W];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cmd_to_word(input cmd_t c, input logic start);
        logic [WORD_W-1:0] w;
        w = '0;
        w[START_BIT]            = start;
        w[RANK_LSB +: RANK_W]   = c.rank;
        w[ARG_LSB +: ARG_W]     = c.arg;
        w[OP_W-1:0]             = c.op;
        return w;
    endfunction

endpackage

// File: rtl/mcmd_regs.sv
module mcmd_regs
    import mcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              done,
    output cmd_t              cmd,
    output logic              start,
    output logic              launch
);

    cmd_t wr_cmd;

    always_comb begin
        wr_cmd = word_to_cmd(wr_data);
        launch = wr_en && !start && wr_data[START_BIT]
                 && op_known(wr_cmd.op) && (wr_cmd.rank != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd   <= '0;
            start <= 1'b0;
        end else if (wr_en && !start) begin
            cmd   <= wr_cmd;
            start <= launch;
        end else if (done) begin
            start <= 1'b0;
        end
    end

endmodule

// File: rtl/mcmd_seq.sv
module mcmd_seq
    import mcmd_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int D_DESEL = 2,
    parameter int D_PREA  = 4,
    parameter int D_REF   = 8,
    parameter int D_MRS   = 3,
    parameter int D_ZQS   = 5,
    parameter int D_ZQL   = 12,
    parameter int D_RSTL  = 6,
    parameter int D_DPDE  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  cmd_t              cmd,
    input  logic              rd_valid,
    output logic              cmd_stb,
    output logic [RANK_W-1:0] cmd_rank,
    output logic              done,
    output logic              capture
);

    seq_e             st;
    logic [CNT_W-1:0] cnt;
    logic             second;
    logic             split;
    logic             last_tick;

    function automatic logic [CNT_W-1:0] op_delay(input logic [OP_W-1:0] op);
        logic [CNT_W-1:0] d;
        case (op)
            OP_DESEL: d = CNT_W'(D_DESEL);
            OP_PREA:  d = CNT_W'(D_PREA);
            OP_REF:   d = CNT_W'(D_REF);
            OP_MRS:   d = CNT_W'(D_MRS);
            OP_ZQS:   d = CNT_W'(D_ZQS);
            OP_ZQL:   d = CNT_W'(D_ZQL);
            OP_RSTL:  d = CNT_W'(D_RSTL);
            OP_DPDE:  d = CNT_W'(D_DPDE);
            default:  d = CNT_W'(1);
        endcase
        return d;
    endfunction

    always_comb begin
        split     = (cmd.op == OP_REF) && (cmd.rank == 2'b11);
        last_tick = (st == S_WAIT) && (cnt <= CNT_W'(1));
        cmd_stb   = (st == S_ISSUE);
        cmd_rank  = split ? (second ? 2'b10 : 2'b01) : cmd.rank;
        capture   = (st == S_WAIT_RD) && rd_valid;
        done      = (last_tick && !(split && !second)) || capture;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            cnt    <= '0;
            second <= 1'b0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (launch) begin
                        st     <= S_ISSUE;
                        second <= 1'b0;
                    end
                end
                S_ISSUE: begin
                    cnt <= op_delay(cmd.op);
                    st  <= (cmd.op == OP_MRR) ? S_WAIT_RD : S_WAIT;
                end
                S_WAIT: begin
                    if (last_tick) begin
                        if (split && !second) begin
                            second <= 1'b1;
                            st     <= S_ISSUE;
                        end else begin
                            st <= S_IDLE;
                        end
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                S_WAIT_RD: begin
                    if (rd_valid) st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mcmd_mrr_stat.sv
module mcmd_mrr_stat #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic [DW-1:0] rd_data,
    output logic [DW-1:0] stat
);

    always_ff @(posedge clk) begin
        if (rst)          stat <= '0;
        else if (capture) stat <= rd_data;
    end

endmodule

// File: rtl/dram_mcmd_top.sv
module dram_mcmd_top
    import mcmd_pkg::*;
#(
    parameter int DW      = 8,
    parameter int CNT_W   = 8,
    parameter int D_DESEL = 2,
    parameter int D_PREA  = 4,
    parameter int D_REF   = 8,
    parameter int D_MRS   = 3,
    parameter int D_ZQS   = 5,
    parameter int D_ZQL   = 12,
    parameter int D_RSTL  = 6,
    parameter int D_DPDE  = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] cmd_rdata,
    output logic [DW-1:0] mrr_stat,
    output logic        cmd_stb,
    output logic [3:0]  cmd_op,
    output logic [1:0]  cmd_rank,
    output logic [15:0] cmd_arg,
    input  logic        rd_valid,
    input  logic [DW-1:0] rd_data
);

    cmd_t cmd;
    logic start, launch, done, capture;

    mcmd_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .done(done), .cmd(cmd), .start(start), .launch(launch)
    );

    mcmd_seq #(
        .CNT_W(CNT_W), .D_DESEL(D_DESEL), .D_PREA(D_PREA), .D_REF(D_REF),
        .D_MRS(D_MRS), .D_ZQS(D_ZQS), .D_ZQL(D_ZQL), .D_RSTL(D_RSTL),
        .D_DPDE(D_DPDE)
    ) u_seq (
        .clk(clk), .rst(rst), .launch(launch), .cmd(cmd), .rd_valid(rd_valid),
        .cmd_stb(cmd_stb), .cmd_rank(cmd_rank), .done(done), .capture(capture)
    );

    mcmd_mrr_stat #(.DW(DW)) u_stat (
        .clk(clk), .rst(rst), .capture(capture), .rd_data(rd_data), .stat(mrr_stat)
    );

    assign cmd_rdata = cmd_to_word(cmd, start);
    assign cmd_op    = cmd.op;
    assign cmd_arg   = cmd.arg;

endmodule

// File: rtl/mcmd_chk.sv
module mcmd_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [31:0]   cmd_rdata,
    input logic [DW-1:0] mrr_stat,
    input logic          cmd_stb,
    input logic [3:0]    cmd_op,
    input logic [1:0]    cmd_rank,
    input logic          rd_valid
);

    // R4: a strobe only occurs while the busy flag reads 1
    a_r4_stb_while_busy: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |-> cmd_rdata[31]);

    // R8: a strobe always selects at least one rank
    a_r8_stb_has_rank: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |-> (cmd_rank != 2'b00));

    // R7: writes during busy leave the recorded fields untouched
    a_r7_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cmd_rdata[31]) |=> $stable(cmd_rdata[30:0]));

    // R9: status only moves on a read-valid cycle
    a_r9_stat_holds: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |=> $stable(mrr_stat));

    // R10: strobe is a single-cycle pulse
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |=> !cmd_stb);

    // R5: every refresh strobe targets exactly one rank
    a_r5_ref_one_rank: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && cmd_op == 4'd2) |-> ($countones(cmd_rank) == 1));

endmodule

bind dram_mcmd_top mcmd_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .cmd_rdata(cmd_rdata),
    .mrr_stat(mrr_stat), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
    .cmd_rank(cmd_rank), .rd_valid(rd_valid)
);

// File: tb/tb_dram_mcmd_top.sv
module tb_dram_mcmd_top;

    localparam int DD = 2, DP = 4, DR = 8, DM = 3, DZS = 5, DZL = 12, DRL = 6, DDP = 7;

    typedef struct packed {
        logic        go;
        logic [3:0]  op;
        logic [1:0]  rank;
        logic [15:0] arg;
        logic [1:0]  n_stb;
        logic [7:0]  busy;
        logic [1:0]  r_first;
        logic [1:0]  r_last;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd0, 2'd1, 16'h0012, 2'd1, 8'(DD+1),      2'd1, 2'd1},
        '{1'b1, 4'd1, 2'd3, 16'h0000, 2'd1, 8'(DP+1),      2'd3, 2'd3},
        '{1'b1, 4'd2, 2'd1, 16'h0001, 2'd1, 8'(DR+1),      2'd1, 2'd1},
        '{1'b1, 4'd2, 2'd2, 16'h0002, 2'd1, 8'(DR+1),      2'd2, 2'd2},
        '{1'b1, 4'd2, 2'd3, 16'h0003, 2'd2, 8'(2*(DR+1)),  2'd1, 2'd2},
        '{1'b1, 4'd3, 2'd1, 16'h0A50, 2'd1, 8'(DM+1),      2'd1, 2'd1},
        '{1'b1, 4'd4, 2'd2, 16'h1234, 2'd1, 8'(DZS+1),     2'd2, 2'd2},
        '{1'b1, 4'd5, 2'd1, 16'hBEEF, 2'd1, 8'(DZL+1),     2'd1, 2'd1},
        '{1'b1, 4'd6, 2'd3, 16'h00FF, 2'd1, 8'(DRL+1),     2'd3, 2'd3},
        '{1'b1, 4'd9, 2'd2, 16'h8001, 2'd1, 8'(DDP+1),     2'd2, 2'd2},
        '{1'b1, 4'd7, 2'd1, 16'h0777, 2'd0, 8'd0,          2'd0, 2'd0},
        '{1'b1, 4'd2, 2'd0, 16'h0004, 2'd0, 8'd0,          2'd0, 2'd0},
        '{1'b1, 4'd15,2'd3, 16'hFFFF, 2'd0, 8'd0,          2'd0, 2'd0},
        '{1'b0, 4'd1, 2'd1, 16'h0042, 2'd0, 8'd0,          2'd0, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] cmd_rdata;
    logic [7:0]  mrr_stat;
    logic        cmd_stb;
    logic [3:0]  cmd_op;
    logic [1:0]  cmd_rank;
    logic [15:0] cmd_arg;
    logic        rd_valid = 1'b0;
    logic [7:0]  rd_data = '0;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    dram_mcmd_top #(
        .DW(8), .CNT_W(8), .D_DESEL(DD), .D_PREA(DP), .D_REF(DR), .D_MRS(DM),
        .D_ZQS(DZS), .D_ZQL(DZL), .D_RSTL(DRL), .D_DPDE(DDP)
    ) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .cmd_rdata(cmd_rdata), .mrr_stat(mrr_stat), .cmd_stb(cmd_stb),
        .cmd_op(cmd_op), .cmd_rank(cmd_rank), .cmd_arg(cmd_arg),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [31:0] mk(logic go, logic [3:0] op, logic [1:0] rank, logic [15:0] arg);
        return {go, 9'b0, rank, arg, op};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Writes one word, then counts busy cycles and strobes until start clears.
    int n_busy, n_stb, n_runs;
    logic [1:0]  first_rank, last_rank;
    logic [3:0]  seen_op;
    logic [15:0] seen_arg;

    task automatic issue_and_watch(input logic [31:0] w, input logic [31:0] extra_w, input int extra_at);
        int cyc;
        logic prev;
        n_busy = 0; n_stb = 0; n_runs = 0;
        first_rank = '0; last_rank = '0; seen_op = '0; seen_arg = '0;
        prev = 1'b0;
        @(negedge clk);
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
        cyc = 0;
        while (cmd_rdata[31] && cyc < 100) begin
            n_busy++;
            if (cmd_stb) begin
                if (n_stb == 0) begin
                    first_rank = cmd_rank; seen_op = cmd_op; seen_arg = cmd_arg;
                end
                last_rank = cmd_rank;
                n_stb++;
                if (prev) n_runs++;
            end
            prev = cmd_stb;
            if (cyc == extra_at) begin wr_en = 1'b1; wr_data = extra_w; end
            else wr_en = 1'b0;
            @(negedge clk);
            cyc++;
        end
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        string tag;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(cmd_rdata == 32'h0, "R1 rdata in reset", cmd_rdata, 32'h0);
        chk(!cmd_stb, "R1 strobe in reset", {31'b0, cmd_stb}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_rdata == 32'h0 && mrr_stat == 8'h0, "R1 after reset",
            {cmd_rdata[23:0], mrr_stat}, 32'h0);

        // Vector table: R2, R3, R4, R5, R8, R10
        for (int i = 0; i < NV; i++) begin
            issue_and_watch(mk(VEC[i].go, VEC[i].op, VEC[i].rank, VEC[i].arg), 32'h0, -1);
            if (VEC[i].n_stb == 0) tag = "R8";
            else if (VEC[i].n_stb == 2) tag = "R5";
            else tag = "R4";
            chk(n_stb == int'(VEC[i].n_stb), {tag, " strobe count"}, n_stb, VEC[i].n_stb);
            chk(n_busy == int'(VEC[i].busy), {tag, " busy cycles"}, n_busy, VEC[i].busy);
            chk(first_rank == VEC[i].r_first && last_rank == VEC[i].r_last,
                {tag, " rank order"}, {first_rank, last_rank}, {VEC[i].r_first, VEC[i].r_last});
            if (VEC[i].n_stb != 0)
                chk(seen_op == VEC[i].op && seen_arg == VEC[i].arg, "R3 strobed op/arg",
                    {seen_op, seen_arg}, {VEC[i].op, VEC[i].arg});
            chk(cmd_rdata == mk(1'b0, VEC[i].op, VEC[i].rank, VEC[i].arg), "R2 readback",
                cmd_rdata, mk(1'b0, VEC[i].op, VEC[i].rank, VEC[i].arg));
            chk(n_runs == 0, "R10 strobe single cycle", n_runs, 0);
        end

        // R6: mode-register read, address 8 at word bits [11:4]
        @(negedge clk);
        wr_en = 1'b1; wr_data = mk(1'b1, 4'd8, 2'd1, 16'h0008);
        @(negedge clk);
        wr_en = 1'b0;
        chk(cmd_stb && cmd_op == 4'd8 && cmd_arg[7:0] == 8'h08, "R6 read strobe with address",
            {cmd_stb, cmd_op, cmd_arg[7:0]}, {1'b1, 4'd8, 8'h08});
        repeat (5) @(negedge clk);
        chk(cmd_rdata[31] && mrr_stat == 8'h00, "R6 waits for read data",
            {cmd_rdata[31], mrr_stat}, {1'b1, 8'h00});
        rd_valid = 1'b1; rd_data = 8'hA7;
        @(negedge clk);
        rd_valid = 1'b0; rd_data = 8'h00;
        chk(!cmd_rdata[31] && mrr_stat == 8'hA7, "R6 capture and complete",
            {cmd_rdata[31], mrr_stat}, {1'b0, 8'hA7});
        chk(mrr_stat[1:0] == 2'b11, "R6 low bits of status", mrr_stat[1:0], 2'b11);

        // R9: read-valid with nothing pending
        rd_valid = 1'b1; rd_data = 8'h55;
        @(negedge clk);
        rd_valid = 1'b0;
        @(negedge clk);
        chk(mrr_stat == 8'hA7, "R9 stray read-valid ignored", mrr_stat, 8'hA7);

        // R7: write during a long calibration
        issue_and_watch(mk(1'b1, 4'd5, 2'd1, 16'h00C3), mk(1'b1, 4'd2, 2'd2, 16'h0009), 3);
        chk(n_stb == 1, "R7 no extra strobe", n_stb, 1);
        chk(n_busy == DZL + 1, "R7 busy unaffected", n_busy, DZL + 1);
        chk(cmd_rdata == mk(1'b0, 4'd5, 2'd1, 16'h00C3), "R7 fields kept",
            cmd_rdata, mk(1'b0, 4'd5, 2'd1, 16'h00C3));
        repeat (3) @(negedge clk);
        chk(!cmd_stb && !cmd_rdata[31], "R7 nothing launched later",
            {cmd_stb, cmd_rdata[31]}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule